// File: doc/BRIEF.md
# Glitch-Free System Clock Source Selector

This block chooses which of up to eight oscillator clocks drives the system clock, and applies an integer post-divider to the chosen clock. Software programs it through a small register file clocked by a bus clock. To change the source, software writes a source code together with a start bit. The block refuses the change when that source does not exist or does not report itself ready. Otherwise it turns the old oscillator off, waits until that has taken effect, turns the new oscillator on, and then records the new code in a read-only field. The start bit clears by itself once the request has been either completed or refused.

Each oscillator has its own gating cell. The cell synchronises its enable through two flops on the rising edges of that oscillator, and opens or closes the gate only on a falling edge. For this reason the switched clock never carries a runt pulse. The post-divider runs on the switched clock. It can jump straight to a new divide value, or walk there one step at a time, holding each intermediate value for a programmable number of output periods. A busy flag is visible to software until the divider has reached the value that was written.

The control and divider registers are protected by a two-word unlock sequence. Each unlock opens exactly one write.

Top module: `sysclk_switcher`

## Requirements
- R1: After reset every register field reads zero, including the busy flag. Source 0 drives the output undivided.
- R2: Register addresses are 0 for control, 1 for divider and 2 for key. Writing 32'hC1A50F3E and then 32'h3E0FA5C1 to the key register opens exactly one write to register 0 or 1. A write to register 0 or 1 without this sequence is ignored. Any other key write, and every write to register 0 or 1, closes the lock again.
- R3: The control register has a read-only current-source field at bits 14:12, a new-source field at bits 10:8 and a start bit at bit 0. Writing the start bit as 1 begins a switch, and the hardware clears the bit when the switch is finished.
- R4: A switch to a source that exists and is ready ends with the current-source field equal to the new code. The output clock then runs at that oscillator's period.
- R5: A switch is refused when the code is at or above the source count, or when the source's ready input is low. The start bit clears, and both the current-source field and the output clock stay as they were.
- R6: A control-register write made while the start bit is still set is ignored, even when the lock is open.
- R7: The divider register's divide field is at bits 23:20. Once the divider has settled, the output period equals the source period times (field + 1).
- R8: The busy flag, bit 0 of the divider register, reads 1 from the cycle after a divide value different from the active one is written. It reads 0 again once the output divider has reached that value.
- R9: In the divider register, bits 10:8 set a hold count, bit 1 enables stepping when the divide value grows, and bit 2 enables stepping when it shrinks. When stepping is enabled for a move, the active value changes by one at a time and each value is held for (hold + 1) output periods. When stepping is disabled, the active value jumps to the target in one move.
- R10: The output never shows a high or low phase shorter than half the period of the fastest oscillator. At most one oscillator gate is open at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock for the register file and switch sequencer |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_clk | input | N_SRC | Oscillator clock inputs |
| osc_ready | input | N_SRC | Per-oscillator ready flags, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register address for writes |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Register address for reads |
| rd_data | output | 32 | Read data, combinational from rd_sel |
| sys_clk | output | 1 | Switched and divided system clock |

## Verification
The bench builds the block with N_SRC = 4. This leaves codes 4 to 7 as absent sources, so the out-of-range refusal path can be exercised alongside the not-ready refusal. The four oscillators have unrelated periods of 8, 12, 16 and 30 ns against a 20 ns bus clock. Every switch therefore crosses asynchronous domains. Period measurement can also tell each source and each divide ratio apart, which is what allows stepped and jumping divider moves to be separated by the intermediate periods they produce.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
    localparam int SEL_W     = 3;
    localparam int SRC_SLOTS = 2 ** SEL_W;
    localparam int DIV_W     = 4;
    localparam int HOLD_W    = 3;
    localparam int BUS_W     = 32;

    localparam logic [BUS_W-1:0] UNLOCK_KEY_A = 32'hC1A5_0F3E;
    localparam logic [BUS_W-1:0] UNLOCK_KEY_B = 32'h3E0F_A5C1;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_DIV  = 2'd1;
    localparam logic [1:0] REG_KEY  = 2'd2;

    typedef enum logic [1:0] {LK_LOCKED, LK_HALF, LK_OPEN} lock_e;
    typedef enum logic [1:0] {SW_IDLE, SW_DROP, SW_RAISE} sw_e;

    typedef struct packed {
        logic [DIV_W-1:0]  target;
        logic [HOLD_W-1:0] hold;
        logic              up_en;
        logic              dn_en;
    } div_cfg_t;
endpackage

// File: rtl/sysclk_src_gate.sv
module sysclk_src_gate (
    input  logic osc_clk,
    input  logic rst_n,
    input  logic req,
    output logic gate
);
    logic [1:0] sync_q;
    logic       gate_q;

    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b00;
        else        sync_q <= {sync_q[0], req};
    end

    // The gate changes only while the oscillator is low.
    always_ff @(negedge osc_clk or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= sync_q[1];
    end

    assign gate = gate_q;
endmodule

// File: rtl/sysclk_postdiv.sv
module sysclk_postdiv
    import sysclk_pkg::*;
(
    input  logic             mux_clk,
    input  logic             rst_n,
    input  div_cfg_t         cfg_in,
    output logic [DIV_W-1:0] active_div,
    output logic             div_gate
);
    typedef struct packed {
        div_cfg_t          cfg_s1;
        div_cfg_t          cfg_s2;
        logic [DIV_W-1:0]  active;
        logic [DIV_W-1:0]  cnt;
        logic [HOLD_W-1:0] hold;
    } pd_t;

    pd_t  st_q, st_d;
    logic wrap, grow, step_en;
    logic gate_q;

    always_comb begin
        st_d        = st_q;
        st_d.cfg_s1 = cfg_in;
        st_d.cfg_s2 = st_q.cfg_s1;
        wrap        = (st_q.cnt == st_q.active);
        grow        = (st_q.cfg_s2.target > st_q.active);
        step_en     = grow ? st_q.cfg_s2.dn_en : st_q.cfg_s2.up_en;
        st_d.cnt    = wrap ? '0 : st_q.cnt + 1'b1;
        if (wrap) begin
            if (st_q.cfg_s2.target == st_q.active) begin
                st_d.hold = '0;
            end else if (!step_en) begin
                st_d.active = st_q.cfg_s2.target;
                st_d.hold   = '0;
            end else if (st_q.hold == st_q.cfg_s2.hold) begin
                st_d.active = grow ? st_q.active + 1'b1 : st_q.active - 1'b1;
                st_d.hold   = '0;
            end else begin
                st_d.hold = st_q.hold + 1'b1;
            end
        end
    end

    always_ff @(posedge mux_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(negedge mux_clk or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= (st_q.cnt == '0);
    end

    assign active_div = st_q.active;
    assign div_gate   = gate_q;

    AST_CNT_BOUND: assert property (@(posedge mux_clk) disable iff (!rst_n)
        st_q.cnt <= st_q.active); // R7
    AST_SLEW_STEP: assert property (@(posedge mux_clk) disable iff (!rst_n)
        (wrap && step_en && st_q.cfg_s2.target != st_q.active) |=>
        ($stable(st_q.active) || st_q.active == $past(st_q.active) + 4'd1 ||
         st_q.active == $past(st_q.active) - 4'd1)); // R9
endmodule

// File: rtl/sysclk_regs.sv
module sysclk_regs
    import sysclk_pkg::*;
#(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [BUS_W-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    output logic [BUS_W-1:0] rd_data,
    input  logic [N_SRC-1:0] osc_ready,
    input  logic [N_SRC-1:0] gate_raw,
    input  logic [DIV_W-1:0] active_div,
    output logic [N_SRC-1:0] src_req,
    output div_cfg_t         cfg
);
    typedef struct packed {
        lock_e             lock;
        sw_e               fsm;
        logic              swen;
        logic [SEL_W-1:0]  nsrc;
        logic [SEL_W-1:0]  csrc;
        logic [N_SRC-1:0]  req;
        div_cfg_t          cfg;
        logic [N_SRC-1:0]  rdy_s1;
        logic [N_SRC-1:0]  rdy_s2;
        logic [N_SRC-1:0]  ack_s1;
        logic [N_SRC-1:0]  ack_s2;
        logic [DIV_W-1:0]  act_s1;
        logic [DIV_W-1:0]  act_s2;
    } rs_t;

    rs_t                  st_q, st_d;
    logic [SRC_SLOTS-1:0] rdy_pad, ack_pad;
    logic                 code_ok, busy;

    for (genvar g = 0; g < SRC_SLOTS; g++) begin : g_pad
        if (g < N_SRC) begin : g_real
            assign rdy_pad[g] = st_q.rdy_s2[g];
            assign ack_pad[g] = st_q.ack_s2[g];
        end else begin : g_absent
            assign rdy_pad[g] = 1'b0;
            assign ack_pad[g] = 1'b0;
        end
    end

    assign code_ok = (int'(st_q.nsrc) < N_SRC);
    assign busy    = (st_q.cfg.target != st_q.act_s2);

    always_comb begin
        st_d        = st_q;
        st_d.rdy_s1 = osc_ready;
        st_d.rdy_s2 = st_q.rdy_s1;
        st_d.ack_s1 = gate_raw;
        st_d.ack_s2 = st_q.ack_s1;
        st_d.act_s1 = active_div;
        st_d.act_s2 = st_q.act_s1;

        if (wr_en) begin
            case (wr_sel)
                REG_KEY: begin
                    if (wr_data == UNLOCK_KEY_A)
                        st_d.lock = LK_HALF;
                    else if (st_q.lock == LK_HALF && wr_data == UNLOCK_KEY_B)
                        st_d.lock = LK_OPEN;
                    else
                        st_d.lock = LK_LOCKED;
                end
                REG_CTRL: begin
                    if (st_q.lock == LK_OPEN && !st_q.swen) begin
                        st_d.nsrc = wr_data[10:8];
                        st_d.swen = wr_data[0];
                    end
                    st_d.lock = LK_LOCKED;
                end
                REG_DIV: begin
                    if (st_q.lock == LK_OPEN) begin
                        st_d.cfg.target = wr_data[23:20];
                        st_d.cfg.hold   = wr_data[10:8];
                        st_d.cfg.up_en  = wr_data[2];
                        st_d.cfg.dn_en  = wr_data[1];
                    end
                    st_d.lock = LK_LOCKED;
                end
                default: ;
            endcase
        end

        case (st_q.fsm)
            SW_IDLE: begin
                if (st_q.swen) begin
                    if (!(code_ok && rdy_pad[st_q.nsrc]) || st_q.nsrc == st_q.csrc) begin
                        st_d.swen = 1'b0;
                    end else begin
                        st_d.req = '0;
                        st_d.fsm = SW_DROP;
                    end
                end
            end
            SW_DROP: begin
                if (!ack_pad[st_q.csrc]) begin
                    for (int i = 0; i < N_SRC; i++)
                        st_d.req[i] = (int'(st_q.nsrc) == i);
                    st_d.fsm = SW_RAISE;
                end
            end
            SW_RAISE: begin
                if (ack_pad[st_q.nsrc]) begin
                    st_d.csrc = st_q.nsrc;
                    st_d.swen = 1'b0;
                    st_d.fsm  = SW_IDLE;
                end
            end
            default: st_d.fsm = SW_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.req <= N_SRC'(1);
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_sel)
            REG_CTRL: begin
                rd_data[14:12] = st_q.csrc;
                rd_data[10:8]  = st_q.nsrc;
                rd_data[0]     = st_q.swen;
            end
            REG_DIV: begin
                rd_data[23:20] = st_q.cfg.target;
                rd_data[10:8]  = st_q.cfg.hold;
                rd_data[2]     = st_q.cfg.up_en;
                rd_data[1]     = st_q.cfg.dn_en;
                rd_data[0]     = busy;
            end
            default: ;
        endcase
    end

    assign src_req = st_q.req;
    assign cfg     = st_q.cfg;

    AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.req)); // R10
    AST_LOCKED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == REG_CTRL && st_q.lock != LK_OPEN) |=> $stable(st_q.nsrc)); // R2
    AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == REG_CTRL && st_q.swen) |=> $stable(st_q.nsrc)); // R6
    AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fsm == SW_IDLE && st_q.swen && !(code_ok && rdy_pad[st_q.nsrc]))
        |=> (!st_q.swen && $stable(st_q.csrc))); // R5
    AST_CUR_ON_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.csrc != $past(st_q.csrc)) |-> ($past(st_q.fsm) == SW_RAISE)); // R4
endmodule

// File: rtl/sysclk_switcher.sv
module sysclk_switcher
    import sysclk_pkg::*;
#(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] osc_clk,
    input  logic [N_SRC-1:0] osc_ready,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [31:0]      wr_data,
    input  logic [1:0]       rd_sel,
    output logic [31:0]      rd_data,
    output logic             sys_clk
);
    logic [N_SRC-1:0] src_req, gate_vec;
    logic [DIV_W-1:0] active_div;
    div_cfg_t         cfg;
    logic             mux_clk, div_gate;

    sysclk_regs #(.N_SRC(N_SRC)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .rd_sel     (rd_sel),
        .rd_data    (rd_data),
        .osc_ready  (osc_ready),
        .gate_raw   (gate_vec),
        .active_div (active_div),
        .src_req    (src_req),
        .cfg        (cfg)
    );

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        sysclk_src_gate gate_i (
            .osc_clk (osc_clk[g]),
            .rst_n   (rst_n),
            .req     (src_req[g]),
            .gate    (gate_vec[g])
        );
    end

    assign mux_clk = |(osc_clk & gate_vec);

    sysclk_postdiv postdiv_i (
        .mux_clk    (mux_clk),
        .rst_n      (rst_n),
        .cfg_in     (cfg),
        .active_div (active_div),
        .div_gate   (div_gate)
    );

    assign sys_clk = mux_clk & div_gate;

    AST_ONE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gate_vec)); // R10
endmodule

// File: tb/sysclk_switcher_tb.sv
`timescale 1ns/1ps
module sysclk_switcher_tb_top;
    localparam int NS = 4;
    localparam logic [31:0] KA = 32'hC1A5_0F3E;
    localparam logic [31:0] KB = 32'h3E0F_A5C1;
    localparam int PER [NS] = '{8, 12, 16, 30};

    logic clk = 1'b0, rst_n = 1'b0;
    logic o0 = 1'b0, o1 = 1'b0, o2 = 1'b0, o3 = 1'b0;
    logic [NS-1:0] osc_ready = '1;
    logic wr_en = 1'b0;
    logic [1:0] wr_sel = '0, rd_sel = '0;
    logic [31:0] wr_data = '0, rd_data;
    logic sys_clk;
    int tests = 0, fails = 0, glitches = 0;
    bit done = 0;
    realtime t_rise = 0.0, t_fall = 0.0;
    bit seen_fall = 0;

    always #10 clk = ~clk;
    always #4  o0 = ~o0;
    always #6  o1 = ~o1;
    always #8  o2 = ~o2;
    always #15 o3 = ~o3;

    sysclk_switcher #(.N_SRC(NS)) dut_i (
        .clk(clk), .rst_n(rst_n), .osc_clk({o3, o2, o1, o0}), .osc_ready(osc_ready),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .sys_clk(sys_clk));

    // pulse-width monitor, fastest oscillator half period is 4 ns
    always @(posedge sys_clk) begin
        if (seen_fall && ($realtime - t_fall) < 3.99) glitches++;
        t_rise = $realtime;
    end
    always @(negedge sys_clk) begin
        if (($realtime - t_rise) < 3.99) glitches++;
        t_fall = $realtime;
        seen_fall = 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [31:0] v);
        @(negedge clk); rd_sel = s; #1 v = rd_data;
    endtask

    task automatic unlock();
        wr(2'd2, KA); wr(2'd2, KB);
    endtask

    task automatic wait_bit0(input logic [1:0] s, input int lim);
        logic [31:0] v;
        for (int i = 0; i < lim; i++) begin
            rd(s, v);
            if (!v[0]) break;
        end
    endtask

    task automatic period_ps(output int p);
        realtime t0;
        @(posedge sys_clk); t0 = $realtime;
        @(posedge sys_clk); p = int'(($realtime - t0) * 1000.0);
    endtask

    task automatic settled_period(output int p);
        repeat (3) @(posedge sys_clk);
        period_ps(p);
    endtask

    function automatic int exp_cur(int cur, int nw, logic [NS-1:0] rdy);
        return (nw < NS && rdy[nw]) ? nw : cur;
    endfunction

    function automatic logic [31:0] div_word(int dv, int hold, bit up, bit dn);
        return (32'(dv) << 20) | (32'(hold) << 8) | (32'(up) << 2) | (32'(dn) << 1);
    endfunction

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        int p, cur, dv;
        bit [15:0] seen;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);

        // R1 reset state
        rd(2'd0, v); chk("R1 ctrl reset", int'(v), 0);
        rd(2'd1, v); chk("R1 div reset", int'(v), 0);
        settled_period(p); chk("R1 source0 undivided", p, 8000);

        // R2 locked write ignored
        wr(2'd0, 32'h0000_0101);
        rd(2'd0, v); chk("R2 locked ctrl write", int'(v), 0);
        wr(2'd2, KA); wr(2'd2, 32'h1234_5678); wr(2'd0, 32'h0000_0101);
        rd(2'd0, v); chk("R2 wrong second key", int'(v), 0);

        // R3 R4 switch to source 1
        unlock(); wr(2'd0, 32'h0000_0101);
        wait_bit0(2'd0, 400);
        rd(2'd0, v); chk("R3 R4 switch to 1", int'(v), 32'h0000_1100);
        settled_period(p); chk("R4 period src1", p, 12000);
        wr(2'd0, 32'h0000_0201);
        rd(2'd0, v); chk("R2 lock rearmed", int'(v[10:8]), 1);

        // R6 write during a switch ignored
        unlock(); wr(2'd0, 32'h0000_0301);
        unlock(); wr(2'd0, 32'h0000_0001);
        rd(2'd0, v); chk("R6 new field kept", int'(v[10:8]), 3);
        wait_bit0(2'd0, 400);
        rd(2'd0, v); chk("R6 R4 landed on 3", int'(v[14:12]), 3);
        settled_period(p); chk("R4 period src3", p, 30000);

        // R5 refusals
        osc_ready[2] = 1'b0; repeat (5) @(negedge clk);
        unlock(); wr(2'd0, 32'h0000_0201);
        wait_bit0(2'd0, 400);
        rd(2'd0, v); chk("R5 not ready keeps cur", int'(v[14:12]), 3);
        chk("R5 start bit cleared", int'(v[0]), 0);
        unlock(); wr(2'd0, 32'h0000_0601);
        wait_bit0(2'd0, 400);
        rd(2'd0, v); chk("R5 absent code keeps cur", int'(v[14:12]), 3);
        settled_period(p); chk("R5 clock unchanged", p, 30000);
        osc_ready[2] = 1'b1;

        // back to source 1 for divider tests
        unlock(); wr(2'd0, 32'h0000_0101);
        wait_bit0(2'd0, 400);
        rd(2'd0, v); chk("R4 back to 1", int'(v[14:12]), 1);

        // R7 R8 plain divide
        unlock(); wr(2'd1, div_word(3, 0, 0, 0));
        rd(2'd1, v); chk("R8 busy after write", int'(v[0]), 1);
        wait_bit0(2'd1, 2000);
        rd(2'd1, v); chk("R8 busy cleared", int'(v[0]), 0);
        settled_period(p); chk("R7 divide by 4", p, 48000);

        // R9 stepped growth 4 -> 8 with hold 1
        seen = '0;
        unlock(); wr(2'd1, div_word(7, 1, 0, 1));
        for (int k = 0; k < 30; k++) begin
            period_ps(p);
            seen[(p + 6000) / 12000] = 1'b1;
        end
        chk("R9 stepped intermediates", int'(seen[7:5]), 7);
        wait_bit0(2'd1, 2000);
        settled_period(p); chk("R7 divide by 8", p, 96000);

        // R9 jump when shrink stepping disabled
        seen = '0;
        unlock(); wr(2'd1, div_word(1, 1, 0, 1));
        for (int k = 0; k < 12; k++) begin
            period_ps(p);
            seen[(p + 6000) / 12000] = 1'b1;
        end
        chk("R9 jump has no intermediates", int'(seen[7:3]), 0);
        wait_bit0(2'd1, 2000);
        settled_period(p); chk("R7 divide by 2", p, 24000);

        // random switching, divider back to 1
        unlock(); wr(2'd1, div_word(0, 0, 0, 0));
        wait_bit0(2'd1, 2000);
        cur = 1;
        for (int it = 0; it < 12; it++) begin
            int nw;
            nw = int'($urandom_range(0, 7));
            osc_ready[2] = 1'($urandom_range(0, 1));
            repeat (5) @(negedge clk);
            unlock(); wr(2'd0, (32'(nw) << 8) | 32'h1);
            wait_bit0(2'd0, 400);
            cur = exp_cur(cur, nw, osc_ready);
            rd(2'd0, v); chk("R4 R5 random current", int'(v[14:12]), cur);
            settled_period(p); chk("R4 R5 random period", p, PER[cur] * 1000);
        end

        // corner: divide field max on slowest path
        unlock(); wr(2'd0, 32'h0000_0001);
        wait_bit0(2'd0, 400);
        unlock(); wr(2'd1, div_word(15, 0, 0, 0));
        wait_bit0(2'd1, 2000);
        dv = 16;
        settled_period(p); chk("R7 divide by 16", p, 8000 * dv);

        chk("R10 no short pulses", glitches, 0);
        done = 1;
        finish_run();
    end
endmodule